// File: doc/BRIEF.md
# NFC Target Wake-Up and First-Command Protocol Selector

This controller handles the target side of a near-field contactless front end while it waits to be addressed. It compares a sampled RF field level with a host-programmed detection threshold. When the field is strong enough, it forces the internal enable high on its own, without help from the external enable pin. It then runs a short power-up sequence that involves the host.

A first interrupt, with the field-change bit, tells the host that the oscillator is stable. A second interrupt, with the RX-start bit, marks the arrival of the first initiator frame. The host has to confirm power-up, through its enable bit, before that second interrupt. If it has not done so, the block drops back to power-down.

Once the host has confirmed, the first byte and the length of the first frame select the target role: passive at 106 kbps with SDD, passive at 212/424 kbps, active, type A emulation or type B emulation. The selected role is published in a status byte. A loss of field after wake-up aborts the sequence until the next reset.

Top module: `nfc_tgt_wake`

## Requirements
- R1: With the threshold field (register 0, bits 2:0) at zero, no field level wakes the block: `int_en` follows `ext_en`, and `proto_stat[7]` stays 0.
- R2: A field level strictly greater than a non-zero threshold forces `int_en` high within three clocks while `ext_en` is low. A level equal to the threshold does not.
- R3: Once awake, a high `osc_stable` sets `osc_stat[6]` and sets IRQ status bit 2 (field change).
- R4: `proto_stat[7]` is 1 exactly while the registered comparison "level > non-zero threshold" holds, in every state, including the aborted state.
- R5: A frame strobe that arrives while waiting for the first frame sets IRQ status bit 6 (RX start).
- R6: If the host enable bit (register 2, bit 0) is clear when the first frame arrives, the block returns to power-down with `int_en` low. It stays there until the field has dropped below the threshold and risen again.
- R7: First byte 0x26 or 0x52 selects code 1 (passive 106 kbps with SDD). When card emulation is enabled (register 1, bit 0), the same bytes select code 4 (type A emulation). The code sits in `proto_stat[2:0]`.
- R8: First byte 0x00 with frame length SENSF_LEN (default 5) selects code 2 (passive 212/424). First byte 0xD4 selects code 3 (active target). First byte 0x05 with card emulation enabled selects code 5 (type B emulation).
- R9: `fifo_fwd` pulses for one clock after a recognised first command. When the auto-SDD bit (register 0, bit 5) is set, the pulse is suppressed for 0x26 and 0x52.
- R10: Field loss after wake-up sets IRQ status bit 2 and drops `int_en`. The block then ignores the field until reset.
- R11: An unrecognised first frame sets code 7 and no `fifo_fwd`. The block keeps waiting, so a later valid frame is still classified.
- R12: An `irq_rd` pulse clears all IRQ status bits. `irq` is high while any status bit is set whose mask bit (register 3, 1 = masked) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| field_lvl | input | LVL_W | Sampled RF field level |
| osc_stable | input | 1 | Supply and oscillator stable |
| ext_en | input | 1 | External enable pin |
| rx_vld | input | 1 | One-clock strobe for a received frame |
| rx_byte0 | input | 8 | First byte of the frame |
| rx_len | input | LEN_W | Frame length in bytes |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Register select: 0 detect cfg, 1 mode, 2 host enable, 3 IRQ mask |
| wr_data | input | 8 | Write data |
| irq_rd | input | 1 | Host read of IRQ status (clears it) |
| int_en | output | 1 | Internal enable |
| irq_stat | output | 8 | IRQ status (bit 2 field change, bit 6 RX start) |
| irq | output | 1 | Interrupt line |
| osc_stat | output | 8 | Oscillator status (bit 6 = oscillator ok) |
| proto_stat | output | 8 | Bit 7 live field detect, bits 2:0 protocol code |
| fifo_fwd | output | 1 | Forward the first command to the FIFO |

## Verification
The hardest condition to reach is a host that never confirms power-up, combined with a field that stays present. If the block re-armed carelessly, it would wake again at once and hide the power-down. The bench holds the field high across the unconfirmed frame, checks that `int_en` stays low for several clocks, and only then drops and restores the field to show re-arming. Field loss in the active state is also driven from the ports: after the abort the field is raised again, and the bench confirms that the block stays down while `proto_stat[7]` still tracks the field.

// File: rtl/nfcw_pkg.sv
// Shared types and constants for the NFC target wake-up controller.
// Assumes 3-bit protocol codes and 8-bit command bytes.
package nfcw_pkg;
    typedef enum logic [2:0] {
        ST_OFF, ST_WAKE, ST_WAIT_RX, ST_ACTIVE, ST_ABORT
    } nfcw_state_e;

    localparam logic [2:0] CODE_NONE  = 3'd0;
    localparam logic [2:0] CODE_P106  = 3'd1;
    localparam logic [2:0] CODE_PF    = 3'd2;
    localparam logic [2:0] CODE_ACT   = 3'd3;
    localparam logic [2:0] CODE_EMU_A = 3'd4;
    localparam logic [2:0] CODE_EMU_B = 3'd5;
    localparam logic [2:0] CODE_UNK   = 3'd7;

    localparam logic [7:0] CMD_SENS  = 8'h26;
    localparam logic [7:0] CMD_ALL   = 8'h52;
    localparam logic [7:0] CMD_SENSB = 8'h05;
    localparam logic [7:0] CMD_SENSF = 8'h00;
    localparam logic [7:0] CMD_ATR   = 8'hD4;
endpackage

// File: rtl/nfcw_field_det.sv
// Registered RF field comparator.
// Reports detection when the threshold is non-zero and the level exceeds it.
// Assumes field_lvl is already sampled in the clk domain.
module nfcw_field_det #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] thr_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             det_o
);
    // Register the comparison result once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) det_o <= 1'b0;
        else        det_o <= (thr_i != '0) && (lvl_i > thr_i);
    end

    // R1: a zero threshold never produces a detection.
    p_thr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == '0) |=> !det_o);
endmodule

// File: rtl/nfcw_cmd_class.sv
// Combinational classifier for the first initiator command.
// Uses the first byte, plus the length for the 0x00 command.
// Card emulation remaps the A/B polls.
module nfcw_cmd_class #(
    parameter int LEN_W     = 4,
    parameter int SENSF_LEN = 5
) (
    input  logic [7:0]       byte0_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             cemu_i,
    output logic [2:0]       code_o,
    output logic             known_o,
    output logic             sdd_cmd_o
);
    import nfcw_pkg::*;
    localparam logic [LEN_W-1:0] FLEN = LEN_W'(SENSF_LEN);

    // Map the first byte and the mode to a protocol code.
    always_comb begin
        code_o    = CODE_UNK;
        sdd_cmd_o = 1'b0;
        if (byte0_i == CMD_SENS || byte0_i == CMD_ALL) begin
            code_o    = cemu_i ? CODE_EMU_A : CODE_P106;
            sdd_cmd_o = 1'b1;
        end else if (byte0_i == CMD_SENSF && len_i == FLEN) begin
            code_o = CODE_PF;
        end else if (byte0_i == CMD_ATR) begin
            code_o = CODE_ACT;
        end else if (byte0_i == CMD_SENSB && cemu_i) begin
            code_o = CODE_EMU_B;
        end
        known_o = (code_o != CODE_UNK);
    end
endmodule

// File: rtl/nfcw_irq_stat.sv
// Sticky IRQ status bits with read-to-clear and a masked interrupt line.
// A set in the same cycle as a read wins over the clear.
module nfcw_irq_stat #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] stat_o,
    output logic         pin_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold each status bit until the host reads it.
        always_ff @(posedge clk) begin
            if (!rst_n)        stat_o[i] <= 1'b0;
            else if (set_i[i]) stat_o[i] <= 1'b1;
            else if (rd_i)     stat_o[i] <= 1'b0;
        end
    end

    // Drive the interrupt line from the unmasked status bits.
    always_comb pin_o = |(stat_o & ~mask_i);

    // R12: a read with no new event empties the status.
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && set_i == '0) |=> (stat_o == '0));
endmodule

// File: rtl/nfc_tgt_wake.sv
// NFC target wake-up sequencer and protocol selector (top level).
// Wakes on field strength and waits for the oscillator. Needs host confirmation
// before the first frame, classifies that frame and aborts on field loss.
// Assumes rx_vld is a single-cycle strobe with rx_byte0/rx_len valid alongside.
module nfc_tgt_wake #(
    parameter int LVL_W     = 3,
    parameter int LEN_W     = 4,
    parameter int SENSF_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] field_lvl,
    input  logic             osc_stable,
    input  logic             ext_en,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte0,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             irq_rd,
    output logic             int_en,
    output logic [7:0]       irq_stat,
    output logic             irq,
    output logic [7:0]       osc_stat,
    output logic [7:0]       proto_stat,
    output logic             fifo_fwd
);
    import nfcw_pkg::*;
    localparam int BIT_FC = 2;
    localparam int BIT_RX = 6;

    nfcw_state_e      st;
    logic [LVL_W-1:0] thr;
    logic             auto_sdd, cemu, host_en, armed, osc_ok, det;
    logic [7:0]       mask, irq_set;
    logic [2:0]       code, cls_code;
    logic             cls_known, cls_sdd, awake, fc_set, rx_set;

    // Host-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0; auto_sdd <= 1'b0; cemu <= 1'b0;
            host_en <= 1'b0; mask <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: begin thr <= wr_data[LVL_W-1:0]; auto_sdd <= wr_data[5]; end
                2'd1: cemu    <= wr_data[0];
                2'd2: host_en <= wr_data[0];
                default: mask <= wr_data;
            endcase
        end
    end

    nfcw_field_det #(.LVL_W(LVL_W)) u_det (
        .clk(clk), .rst_n(rst_n), .thr_i(thr), .lvl_i(field_lvl), .det_o(det));

    nfcw_cmd_class #(.LEN_W(LEN_W), .SENSF_LEN(SENSF_LEN)) u_cls (
        .byte0_i(rx_byte0), .len_i(rx_len), .cemu_i(cemu),
        .code_o(cls_code), .known_o(cls_known), .sdd_cmd_o(cls_sdd));

    // Decode the awake states and the interrupt events.
    always_comb begin
        awake   = (st == ST_WAKE) || (st == ST_WAIT_RX) || (st == ST_ACTIVE);
        fc_set  = (awake && !det) || (st == ST_WAKE && det && osc_stable);
        rx_set  = det && rx_vld && ((st == ST_WAIT_RX) || (st == ST_ACTIVE));
        irq_set = '0;
        irq_set[BIT_FC] = fc_set;
        irq_set[BIT_RX] = rx_set;
    end

    nfcw_irq_stat #(.W(8)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .rd_i(irq_rd),
        .mask_i(mask), .stat_o(irq_stat), .pin_o(irq));

    // Wake-up sequence, first-command classification and abort handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OFF; armed <= 1'b1; osc_ok <= 1'b0;
            code <= CODE_NONE; fifo_fwd <= 1'b0;
        end else begin
            fifo_fwd <= 1'b0;
            case (st)
                ST_OFF: begin
                    if (!det) armed <= 1'b1;
                    else if (armed) begin
                        st <= ST_WAKE; code <= CODE_NONE;
                    end
                end
                ST_WAKE: begin
                    if (!det) st <= ST_ABORT;
                    else if (osc_stable) begin
                        st <= ST_WAIT_RX; osc_ok <= 1'b1;
                    end
                end
                ST_WAIT_RX: begin
                    if (!det) begin
                        st <= ST_ABORT; osc_ok <= 1'b0;
                    end else if (rx_vld) begin
                        if (!host_en) begin
                            st <= ST_OFF; armed <= 1'b0; osc_ok <= 1'b0;
                        end else begin
                            code <= cls_code;
                            if (cls_known) begin
                                st       <= ST_ACTIVE;
                                fifo_fwd <= !(auto_sdd && cls_sdd);
                            end
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (!det) begin
                        st <= ST_ABORT; osc_ok <= 1'b0;
                    end
                end
                default: st <= ST_ABORT;
            endcase
        end
    end

    // Drive the status bytes and the enable.
    always_comb begin
        int_en     = ext_en | awake;
        osc_stat   = {1'b0, osc_ok, 6'b0};
        proto_stat = {det, 4'b0, code};
    end

    p_force_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAKE) |-> int_en);
    p_oscirq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_ok) |-> irq_stat[BIT_FC]);
    p_rxirq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_RX && rx_vld && det) |=> irq_stat[BIT_RX]);
    p_noconf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_RX && rx_vld && det && !host_en && !ext_en) |=> !int_en);
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT) |=> (st == ST_ABORT));
endmodule

// File: tb/nfc_tgt_wake_bench.sv
// Self-checking bench: a table of first commands, then directed corner tests.
module nfc_tgt_wake_bench;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] field_lvl = '0;
    logic       osc_stable = 1'b0, ext_en = 1'b0, rx_vld = 1'b0;
    logic [7:0] rx_byte0 = '0;
    logic [3:0] rx_len = '0;
    logic       wr_en = 1'b0, irq_rd = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       int_en, irq, fifo_fwd;
    logic [7:0] irq_stat, osc_stat, proto_stat;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    nfc_tgt_wake u_nfc_tgt_wake (.*);

    // byte0[17:10] len[9:6] cemu[5] auto_sdd[4] code[3:1] fwd[0]
    localparam logic [17:0] TBL [8] = '{
        {8'h26, 4'd1, 1'b0, 1'b0, 3'd1, 1'b1},
        {8'h52, 4'd1, 1'b0, 1'b1, 3'd1, 1'b0},
        {8'h26, 4'd1, 1'b1, 1'b0, 3'd4, 1'b1},
        {8'h00, 4'd5, 1'b0, 1'b0, 3'd2, 1'b1},
        {8'hD4, 4'd8, 1'b0, 1'b1, 3'd3, 1'b1},
        {8'h05, 4'd3, 1'b1, 1'b0, 3'd5, 1'b1},
        {8'h00, 4'd3, 1'b0, 1'b0, 3'd7, 1'b0},
        {8'h05, 4'd3, 1'b0, 1'b0, 3'd7, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; field_lvl = '0; osc_stable = 1'b0;
        ext_en = 1'b0; rx_vld = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_rd = 1'b1;
        @(negedge clk); irq_rd = 1'b0;
    endtask

    task automatic wake();
        wr(2'd0, 8'h03);
        field_lvl = 3'd5; osc_stable = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Pulse one frame; sample just after the capturing edge.
    task automatic frame(input logic [7:0] b, input logic [3:0] l, output logic fw);
        @(negedge clk); rx_vld = 1'b1; rx_byte0 = b; rx_len = l;
        @(posedge clk); #1 fw = fifo_fwd;
        @(negedge clk); rx_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic fw;
        do_reset();
        chk("R12 reset irq_stat", irq_stat, 0);
        chk("R1 reset int_en", int_en, 0);
        chk("R4 reset proto", proto_stat, 0);

        // Table of first commands.
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(2'd1, {7'd0, TBL[i][5]});
            wr(2'd2, 8'h01);
            wr(2'd0, {2'b00, TBL[i][4], 5'b00011});
            field_lvl = 3'd5; osc_stable = 1'b1;
            repeat (4) @(negedge clk);
            chk("R3 osc_ok", osc_stat, 8'h40);
            chk("R3 field-change irq", irq_stat, 8'h04);
            frame(TBL[i][17:10], TBL[i][9:6], fw);
            chk("R7/R8 proto code", proto_stat, {1'b1, 4'b0, TBL[i][3:1]});
            chk("R9 fifo_fwd", fw, TBL[i][0]);
            chk("R5 rx-start irq", irq_stat[6], 1);
        end

        // R1: zero threshold, strong field.
        do_reset();
        field_lvl = 3'd7; repeat (5) @(negedge clk);
        chk("R1 no wake", int_en, 0);
        chk("R1 no detect", proto_stat[7], 0);
        ext_en = 1'b1; #1 chk("R1 ext_en passes", int_en, 1); ext_en = 1'b0;

        // R2: equal level does not wake, greater does.
        wr(2'd0, 8'h04); field_lvl = 3'd4; repeat (4) @(negedge clk);
        chk("R2 equal level", int_en, 0);
        field_lvl = 3'd5; repeat (3) @(negedge clk);
        chk("R2 forced enable", int_en, 1);
        chk("R4 mirror", proto_stat[7], 1);
        chk("R3 waits for osc", osc_stat, 0);

        // R12: mask and read-clear.
        osc_stable = 1'b1; repeat (2) @(negedge clk);
        chk("R12 irq line", irq, 1);
        wr(2'd3, 8'h04); #1 chk("R12 masked", irq, 0);
        clr_irq(); chk("R12 cleared", irq_stat, 0);
        wr(2'd3, 8'h00);

        // R6: first frame without host confirmation.
        frame(8'h26, 4'd1, fw);
        repeat (4) @(negedge clk);
        chk("R6 power-down", int_en, 0);
        chk("R6 rx irq", irq_stat[6], 1);
        chk("R6 no forward", fw, 0);
        field_lvl = 3'd0; repeat (3) @(negedge clk);
        field_lvl = 3'd6; repeat (4) @(negedge clk);
        chk("R6 re-armed", int_en, 1);

        // R11: unknown then valid.
        wr(2'd2, 8'h01);
        frame(8'h99, 4'd2, fw);
        chk("R11 unknown code", proto_stat[2:0], 7);
        chk("R11 no forward", fw, 0);
        frame(8'hD4, 4'd6, fw);
        chk("R11 later frame", proto_stat[2:0], 3);

        // R10: field loss in active state, then field returns.
        clr_irq();
        field_lvl = 3'd1; repeat (3) @(negedge clk);
        chk("R10 field irq", irq_stat[2], 1);
        chk("R10 enable drops", int_en, 0);
        chk("R4 mirror low", proto_stat[7], 0);
        field_lvl = 3'd7; repeat (5) @(negedge clk);
        chk("R10 stays down", int_en, 0);
        chk("R4 mirror in abort", proto_stat[7], 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule